// File: doc/BRIEF.md
# Resolver Signal Fault Monitor

This block watches the health of a resolver interface. Once per excitation period the front end hands it the measured peak amplitudes of the sine and cosine channels, marked by a one-cycle valid strobe. A signed tracking-error word from the angle loop arrives on every cycle. The block compares these values against five thresholds that the host programs on its own, and it drives two active-low status pins. The degradation pin covers over-range on either channel and a sine/cosine amplitude mismatch. The tracking pin reports loss of position tracking.

An 8-bit fault register collects the individual conditions, including loss of both signals. The register is updated only when the host's sample input goes from high to low. Each update ORs the present conditions into the bits already held, so every bit stays set until the host pulses the clear input. The tracking pin follows its condition directly and is never latched. The amplitude conditions are held from one valid strobe to the next.

Top module: `rsl_fault_monitor`

## Requirements
- R1: After reset, sig_bad_n and trk_lost_n are 1 and fault_reg is 0. The thresholds hold their defaults: low-signal 200, sine high 3500, cosine high 3500, mismatch 400, tracking 100.
- R2: Loss of signal (fault bit 0) is present when both the sine and cosine amplitudes are strictly below the low-signal threshold. One channel below the threshold on its own does not raise it.
- R3: One cycle after a clock edge that samples amp_valid=1, sig_bad_n goes low if sine > sine-high (fault bit 1), cosine > cosine-high (fault bit 2), or a mismatch exists. Equality with a threshold is not a fault.
- R4: Mismatch (fault bit 3) is present when |sine - cosine| is strictly greater than the mismatch threshold, whichever channel is larger.
- R5: trk_lost_n is low in the cycle after an edge that sees |trk_err| > tracking threshold (fault bit 4), for either sign including the most negative value. It returns high one cycle after the condition ends.
- R6: Fault bit 5 reports sine below the low threshold, bit 6 reports cosine below the low threshold, and bit 7 is set when any of bits 1 to 3 is set.
- R7: The amplitude conditions and sig_bad_n change only at edges that sample amp_valid=1. Amplitude changes without the strobe have no effect.
- R8: fault_reg takes in the current conditions only at the edge where sample is seen low after being high in the previous cycle. A rising edge or a steady level captures nothing.
- R9: fault_reg bits are sticky and clear only on clear. If clear and a sample fall arrive at the same edge, fault_reg becomes exactly the current condition vector.
- R10: A write with cfg_we=1 to address 0 (low-signal), 1 (sine high), 2 (cosine high), 3 (mismatch) or 4 (tracking) loads cfg_wdata. Writes to addresses 5 to 7 change no threshold.
- R11: Loss of signal on its own does not drive sig_bad_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_valid | input | 1 | One-cycle strobe: sin_amp and cos_amp are valid |
| sin_amp | input | 12 | Sine peak amplitude, unsigned |
| cos_amp | input | 12 | Cosine peak amplitude, unsigned |
| trk_err | input | 12 | Tracking error, two's complement |
| cfg_we | input | 1 | Threshold write enable |
| cfg_addr | input | 3 | Threshold select |
| cfg_wdata | input | 12 | Threshold value |
| smp | input | 1 | Sample request; a falling edge updates fault_reg |
| flt_clr | input | 1 | Clears fault_reg |
| sig_bad_n | output | 1 | Active-low signal degradation |
| trk_lost_n | output | 1 | Active-low loss of tracking, live |
| fault_reg | output | 8 | Sticky fault register |

## Verification
The hardest case to reach from the ports is a clear and a sample fall at the same edge while the register already holds a different fault. A one-sided priority would either keep the stale bit or lose the new one. To get there, the stimulus first captures a sine over-range. It then presents a pure mismatch, raises sample, and on one cycle lowers sample and raises clear together, so the expected result differs from both the old contents and zero. The threshold boundaries are reached by reprogramming thresholds and driving amplitudes exactly at, and one code past, each limit.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  // fault register bit positions
  localparam int FB_LOS     = 0;
  localparam int FB_SIN_OVR = 1;
  localparam int FB_COS_OVR = 2;
  localparam int FB_MISM    = 3;
  localparam int FB_TRACK   = 4;
  localparam int FB_SIN_LO  = 5;
  localparam int FB_COS_LO  = 6;
  localparam int FB_DEG_ANY = 7;
  localparam int FAULT_W    = 8;

  // threshold slots
  localparam int TH_LOW   = 0;
  localparam int TH_SIN   = 1;
  localparam int TH_COS   = 2;
  localparam int TH_MISM  = 3;
  localparam int TH_TRACK = 4;
  localparam int TH_COUNT = 5;
endpackage

// File: rtl/rsl_thresh_regs.sv
module rsl_thresh_regs
  import rsl_pkg::*;
#(
  parameter int AW       = 12,
  parameter int ADW      = 3,
  parameter int DEF_LOW  = 200,
  parameter int DEF_SIN  = 3500,
  parameter int DEF_COS  = 3500,
  parameter int DEF_MISM = 400,
  parameter int DEF_TRK  = 100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ADW-1:0]                cfg_addr,
  input  logic [AW-1:0]                 cfg_wdata,
  output logic [TH_COUNT-1:0][AW-1:0]   thr_o
);
  function automatic logic [AW-1:0] default_of(int idx);
    case (idx)
      TH_LOW:   return AW'(DEF_LOW);
      TH_SIN:   return AW'(DEF_SIN);
      TH_COS:   return AW'(DEF_COS);
      TH_MISM:  return AW'(DEF_MISM);
      default:  return AW'(DEF_TRK);
    endcase
  endfunction

  logic addr_hit_none;
  assign addr_hit_none = cfg_we && (int'(cfg_addr) >= TH_COUNT);

  for (genvar i = 0; i < TH_COUNT; i++) begin : g_thr
    logic sel;
    assign sel = cfg_we && (int'(cfg_addr) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   thr_o[i] <= default_of(i);
      else if (sel) thr_o[i] <= cfg_wdata;
    end
  end

  // R10: unmapped writes leave all thresholds untouched
  a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit_none |=> $stable(thr_o));
endmodule

// File: rtl/rsl_amp_check.sv
module rsl_amp_check
  import rsl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          amp_valid,
  input  logic [AW-1:0] sin_amp,
  input  logic [AW-1:0] cos_amp,
  input  logic [AW-1:0] thr_low,
  input  logic [AW-1:0] thr_sin,
  input  logic [AW-1:0] thr_cos,
  input  logic [AW-1:0] thr_mism,
  output logic          los_q,
  output logic          sin_ovr_q,
  output logic          cos_ovr_q,
  output logic          mism_q,
  output logic          sin_lo_q,
  output logic          cos_lo_q,
  output logic          sig_bad_n
);
  function automatic logic [AW-1:0] amp_gap(logic [AW-1:0] a, logic [AW-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // named events of the present strobe
  logic sin_lo_now, cos_lo_now, los_now, sin_ovr_now, cos_ovr_now, mism_now, deg_now;
  assign sin_lo_now  = sin_amp < thr_low;
  assign cos_lo_now  = cos_amp < thr_low;
  assign los_now     = sin_lo_now && cos_lo_now;
  assign sin_ovr_now = sin_amp > thr_sin;
  assign cos_ovr_now = cos_amp > thr_cos;
  assign mism_now    = amp_gap(sin_amp, cos_amp) > thr_mism;
  assign deg_now     = sin_ovr_now || cos_ovr_now || mism_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q     <= 1'b0;
      sin_ovr_q <= 1'b0;
      cos_ovr_q <= 1'b0;
      mism_q    <= 1'b0;
      sin_lo_q  <= 1'b0;
      cos_lo_q  <= 1'b0;
      sig_bad_n <= 1'b1;
    end else if (amp_valid) begin
      los_q     <= los_now;
      sin_ovr_q <= sin_ovr_now;
      cos_ovr_q <= cos_ovr_now;
      mism_q    <= mism_now;
      sin_lo_q  <= sin_lo_now;
      cos_lo_q  <= cos_lo_now;
      sig_bad_n <= !deg_now;
    end
  end

  // R7: no strobe, no change on the degradation pin
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_valid |=> $stable(sig_bad_n) && $stable(los_q));
  // R11: loss of signal alone keeps the pin high
  a_r11_los_not_deg: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && los_now && !mism_now && !sin_ovr_now && !cos_ovr_now) |=> sig_bad_n);
  // R2: captured loss of signal implies both channels were low
  a_r2_los_both: assert property (@(posedge clk) disable iff (!rst_n)
    los_q |-> (sin_lo_q && cos_lo_q));
  // R3: over-range on a strobe pulls the pin low
  a_r3_overrange: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && (sin_ovr_now || cos_ovr_now)) |=> !sig_bad_n);
endmodule

// File: rtl/rsl_track_check.sv
module rsl_track_check #(
  parameter int AW = 12,
  parameter int EW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [EW-1:0] trk_err,
  input  logic [AW-1:0]        thr_trk,
  output logic                 trk_q,
  output logic                 trk_lost_n
);
  localparam int CW = ((AW > EW) ? AW : EW) + 1;

  function automatic logic [EW-1:0] err_mag(logic signed [EW-1:0] e);
    return e[EW-1] ? EW'(-e) : EW'(e);
  endfunction

  logic [CW-1:0] mag_ext, thr_ext;
  logic          over_now;
  assign mag_ext  = {{(CW-EW){1'b0}}, err_mag(trk_err)};
  assign thr_ext  = {{(CW-AW){1'b0}}, thr_trk};
  assign over_now = mag_ext > thr_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk_q <= 1'b0;
    else        trk_q <= over_now;
  end
  assign trk_lost_n = !trk_q;

  // R5: pin follows the condition one cycle later, both directions
  a_r5_assert_low: assert property (@(posedge clk) disable iff (!rst_n)
    over_now |=> !trk_lost_n);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    !over_now |=> trk_lost_n);
endmodule

// File: rtl/rsl_fault_capture.sv
module rsl_fault_capture
  import rsl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp,
  input  logic               flt_clr,
  input  logic [FAULT_W-1:0] live,
  output logic [FAULT_W-1:0] fault_reg
);
  logic smp_q, smp_fall;
  assign smp_fall = smp_q && !smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q     <= 1'b0;
      fault_reg <= '0;
    end else begin
      smp_q     <= smp;
      fault_reg <= (flt_clr ? '0 : fault_reg) | (smp_fall ? live : '0);
    end
  end

  // R9: no bit drops without a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_clr |=> ((fault_reg & $past(fault_reg)) == $past(fault_reg)));
  // R8: without a fall or a clear the register holds
  a_r8_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_fall && !flt_clr) |=> $stable(fault_reg));
  // R9: clear with a fall yields exactly the live vector
  a_r9_clear_and_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_fall && flt_clr) |=> (fault_reg == $past(live)));
endmodule

// File: rtl/rsl_fault_monitor.sv
module rsl_fault_monitor
  import rsl_pkg::*;
#(
  parameter int AW       = 12,
  parameter int EW       = 12,
  parameter int ADW      = 3,
  parameter int DEF_LOW  = 200,
  parameter int DEF_SIN  = 3500,
  parameter int DEF_COS  = 3500,
  parameter int DEF_MISM = 400,
  parameter int DEF_TRK  = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 amp_valid,
  input  logic [AW-1:0]        sin_amp,
  input  logic [AW-1:0]        cos_amp,
  input  logic signed [EW-1:0] trk_err,
  input  logic                 cfg_we,
  input  logic [ADW-1:0]       cfg_addr,
  input  logic [AW-1:0]        cfg_wdata,
  input  logic                 smp,
  input  logic                 flt_clr,
  output logic                 sig_bad_n,
  output logic                 trk_lost_n,
  output logic [7:0]           fault_reg
);
  logic [TH_COUNT-1:0][AW-1:0] thr;
  logic los_q, sin_ovr_q, cos_ovr_q, mism_q, sin_lo_q, cos_lo_q, trk_q;
  logic [FAULT_W-1:0] live_vec;

  rsl_thresh_regs #(
    .AW(AW), .ADW(ADW), .DEF_LOW(DEF_LOW), .DEF_SIN(DEF_SIN),
    .DEF_COS(DEF_COS), .DEF_MISM(DEF_MISM), .DEF_TRK(DEF_TRK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .thr_o(thr)
  );

  rsl_amp_check #(.AW(AW)) u_amp (
    .clk(clk), .rst_n(rst_n), .amp_valid(amp_valid),
    .sin_amp(sin_amp), .cos_amp(cos_amp),
    .thr_low(thr[TH_LOW]), .thr_sin(thr[TH_SIN]), .thr_cos(thr[TH_COS]),
    .thr_mism(thr[TH_MISM]),
    .los_q(los_q), .sin_ovr_q(sin_ovr_q), .cos_ovr_q(cos_ovr_q),
    .mism_q(mism_q), .sin_lo_q(sin_lo_q), .cos_lo_q(cos_lo_q),
    .sig_bad_n(sig_bad_n)
  );

  rsl_track_check #(.AW(AW), .EW(EW)) u_trk (
    .clk(clk), .rst_n(rst_n), .trk_err(trk_err), .thr_trk(thr[TH_TRACK]),
    .trk_q(trk_q), .trk_lost_n(trk_lost_n)
  );

  always_comb begin
    live_vec              = '0;
    live_vec[FB_LOS]      = los_q;
    live_vec[FB_SIN_OVR]  = sin_ovr_q;
    live_vec[FB_COS_OVR]  = cos_ovr_q;
    live_vec[FB_MISM]     = mism_q;
    live_vec[FB_TRACK]    = trk_q;
    live_vec[FB_SIN_LO]   = sin_lo_q;
    live_vec[FB_COS_LO]   = cos_lo_q;
    live_vec[FB_DEG_ANY]  = sin_ovr_q || cos_ovr_q || mism_q;
  end

  rsl_fault_capture u_cap (
    .clk(clk), .rst_n(rst_n), .smp(smp), .flt_clr(flt_clr),
    .live(live_vec), .fault_reg(fault_reg)
  );

  // R6: summary bit never set without one of its sources
  a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_vec[FB_SIN_OVR] && !live_vec[FB_COS_OVR] && !live_vec[FB_MISM]) |-> !live_vec[FB_DEG_ANY]);
endmodule

// File: tb/tb_rsl_fault_monitor.sv
module tb_rsl_fault_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic amp_valid = 1'b0;
  logic [11:0] sin_amp = '0, cos_amp = '0;
  logic signed [11:0] trk_err = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic smp = 1'b0, flt_clr = 1'b0;
  logic sig_bad_n, trk_lost_n;
  logic [7:0] fault_reg;

  int errors = 0, checks = 0;
  int th[5] = '{200, 3500, 3500, 400, 100};
  int cur_s = 0, cur_c = 0, cur_e = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rsl_fault_monitor dut (
    .clk(clk), .rst_n(rst_n), .amp_valid(amp_valid), .sin_amp(sin_amp),
    .cos_amp(cos_amp), .trk_err(trk_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp(smp), .flt_clr(flt_clr),
    .sig_bad_n(sig_bad_n), .trk_lost_n(trk_lost_n), .fault_reg(fault_reg)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected condition vector from the requirement text
  function automatic int model(int s, int c, int e);
    int d = (s > c) ? s - c : c - s;
    int m = (e < 0) ? -e : e;
    bit so = s > th[1], co = c > th[2], mm = d > th[3];
    int v = 0;
    if (s < th[0] && c < th[0]) v |= 1;
    if (so) v |= 2;
    if (co) v |= 4;
    if (mm) v |= 8;
    if (m > th[4]) v |= 16;
    if (s < th[0]) v |= 32;
    if (c < th[0]) v |= 64;
    if (so || co || mm) v |= 128;
    return v;
  endfunction

  function automatic int exp_bad_n(int s, int c);
    return (model(s, c, 0) & 128) ? 0 : 1;
  endfunction

  task automatic put_amp(int s, int c);
    @(negedge clk); sin_amp = 12'(s); cos_amp = 12'(c); amp_valid = 1'b1;
    @(negedge clk); amp_valid = 1'b0;
    cur_s = s; cur_c = c;
  endtask

  task automatic put_err(int e);
    @(negedge clk); trk_err = 12'(e); cur_e = e;
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 12'(d);
    @(negedge clk); cfg_we = 1'b0;
    if (a < 5) th[a] = d;
  endtask

  task automatic sample_pulse();
    @(negedge clk); smp = 1'b1;
    @(negedge clk); smp = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_pulse();
    @(negedge clk); flt_clr = 1'b1;
    @(negedge clk); flt_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 sig_bad_n", sig_bad_n, 1);
    check("R1 trk_lost_n", trk_lost_n, 1);
    check("R1 fault_reg", fault_reg, 0);
    put_amp(2000, 2000); put_err(0);
    check("R1 nominal bad_n", sig_bad_n, 1);
    put_amp(3500, 3400);
    check("R1 default sine high", sig_bad_n, 1);
    put_amp(3501, 3400);
    check("R1 default sine high+1", sig_bad_n, 0);
    put_err(100);
    check("R1 default tracking", trk_lost_n, 1);
    put_amp(199, 199);
    sample_pulse();
    check("R1 default low", fault_reg, model(199, 199, 100));
    clear_pulse();
    check("R9 clear", fault_reg, 0);
  endtask

  task automatic t_overrange();
    put_amp(3500, 3500);
    check("R3 equal not fault", sig_bad_n, 1);
    put_amp(3300, 3501);
    check("R3 cosine over", sig_bad_n, 0);
    sample_pulse();
    check("R3 bits", fault_reg, model(3300, 3501, cur_e));
    clear_pulse();
  endtask

  task automatic t_mismatch();
    put_amp(2000, 1600);
    check("R4 gap equal", sig_bad_n, 1);
    put_amp(2000, 1599);
    check("R4 sine larger", sig_bad_n, 0);
    put_amp(1599, 2000);
    check("R4 cosine larger", sig_bad_n, 0);
    sample_pulse();
    check("R4 bits", fault_reg, 8 | 128);
    clear_pulse();
  endtask

  task automatic t_los();
    put_amp(199, 199);
    check("R11 los keeps pin high", sig_bad_n, 1);
    sample_pulse();
    check("R2 both low", fault_reg, 1 | 32 | 64);
    clear_pulse();
    put_amp(199, 200);
    sample_pulse();
    check("R2 one low only", fault_reg, 32);
    clear_pulse();
    put_amp(200, 150);
    sample_pulse();
    check("R6 cosine low only", fault_reg, 64);
    clear_pulse();
  endtask

  task automatic t_track();
    put_amp(2000, 2000);
    put_err(101);
    check("R5 positive over", trk_lost_n, 0);
    put_err(100);
    check("R5 unlatched release", trk_lost_n, 1);
    put_err(-101);
    check("R5 negative over", trk_lost_n, 0);
    put_err(-100);
    check("R5 negative at limit", trk_lost_n, 1);
    put_err(-2048);
    check("R5 most negative", trk_lost_n, 0);
    sample_pulse();
    check("R5 bit4", fault_reg, 16);
    put_err(0);
    clear_pulse();
  endtask

  task automatic t_hold();
    put_amp(3600, 3600);
    @(negedge clk); sin_amp = 12'd2000; cos_amp = 12'd2000;
    @(negedge clk); @(negedge clk);
    check("R7 no strobe no change", sig_bad_n, 0);
    put_amp(2000, 2000);
    @(negedge clk); sin_amp = 12'd3900;
    @(negedge clk);
    check("R7 ignored change", sig_bad_n, 1);
    sample_pulse();
    check("R7 no strobe bits", fault_reg, 0);
  endtask

  task automatic t_sticky();
    put_amp(3600, 3300);
    @(negedge clk); smp = 1'b1;
    @(negedge clk);
    check("R8 rising no capture", fault_reg, 0);
    @(negedge clk);
    check("R8 steady high no capture", fault_reg, 0);
    smp = 1'b0;
    @(negedge clk);
    check("R8 fall capture", fault_reg, model(3600, 3300, 0));
    put_amp(2000, 2000);
    sample_pulse();
    check("R9 sticky after recovery", fault_reg, model(3600, 3300, 0));
    clear_pulse();
    check("R9 cleared", fault_reg, 0);
  endtask

  task automatic t_clr_fall();
    put_amp(3600, 3300);
    sample_pulse();
    put_amp(2000, 1500);
    @(negedge clk); smp = 1'b1;
    @(negedge clk); smp = 1'b0; flt_clr = 1'b1;
    @(negedge clk); flt_clr = 1'b0;
    check("R9 clear with fall", fault_reg, model(2000, 1500, 0));
    clear_pulse();
  endtask

  task automatic t_cfg();
    wr(7, 0);
    wr(5, 0);
    put_err(50);
    check("R10 unmapped write", trk_lost_n, 1);
    put_amp(2000, 2000);
    check("R10 unmapped write amp", sig_bad_n, 1);
    wr(4, 40);
    put_err(50);
    check("R10 tracking thr", trk_lost_n, 0);
    wr(1, 2500);
    put_amp(2600, 2600);
    check("R10 sine thr", sig_bad_n, 0);
    wr(2, 2700);
    wr(1, 3000);
    put_amp(2600, 2800);
    check("R10 cosine thr", sig_bad_n, 0);
    wr(3, 50);
    put_amp(1000, 1060);
    check("R10 mismatch thr", sig_bad_n, exp_bad_n(1000, 1060));
    wr(0, 1000);
    put_amp(990, 990);
    put_err(0);
    sample_pulse();
    check("R10 low thr", fault_reg, model(990, 990, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_overrange();
    t_mismatch();
    t_los();
    t_track();
    t_hold();
    t_sticky();
    t_clr_fall();
    t_cfg();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule